// File: doc/BRIEF.md
# Timer Capture/Compare Register

This block is the 16-bit capture/compare register of a general-purpose timer. It watches an external counter value and an operating-mode code. From these it decides whether the register latches the counter on an edge of a capture input, or holds a value that the counter is compared against. In compare role it raises a one-clock match pulse when the counter equals the held value.

Software loads the register through a simple write port. In most modes a write lands at once. In the two PWM-style modes a write made while the timer runs goes into a hidden reload buffer. That buffer is copied into the active register at the period boundary, so the new value applies from the next period. In pulse width measurement mode the register only captures, and software writes are dropped. The register value seen on the output is always the active register, never the reload buffer.

Top module: `tmr_capcmp_reg`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it rises, `value_o` is 0x0000 and `match_o` is low. In a compare mode, that zero already serves as the compare value.
- R2: `mode_i` codes are 0 free-running, 1 event count, 2 one-shot, 3 interval, 4 PWM, 5 triggered pulse, 6 pulse width measurement and 7 spare (behaves as 3). In mode 0, `cap_sel_i`=1 selects capture role and `cap_sel_i`=0 selects compare role.
- R3: In mode 6 the role is capture only, and `match_o` never rises.
- R4: In modes 1 to 5 and 7 the role is compare only. `cap_sel_i` and capture-input edges do not change `value_o`.
- R5: In capture role, a change on `cap_i` that matches `edge_sel_i` loads `count_i` into the register. The encodings are 00 none, 01 rising, 10 falling and 11 both. The load happens at the third rising clock edge after the change, and the counter value present at that edge is stored.
- R6: No capture happens while `enable_i` is low.
- R7: In modes 4 and 5 with `enable_i` high, a write goes into the reload buffer and `value_o` does not change.
- R8: In modes 4 and 5, at a clock edge where `enable_i` is high and `count_i` equals `value_o`, the reload buffer moves into the register. It is visible on `value_o` after that edge.
- R9: A write in modes 0 to 3 and 7 takes effect on `value_o` after the next edge. So does a write in modes 4 or 5 with `enable_i` low.
- R10: In mode 6, writes are ignored.
- R11: `match_o` is high in the cycle after a clock edge at which all of these held: the role was compare, `enable_i` was high, and `count_i` equalled `value_o`. Otherwise it is low.
- R12: When a capture and a write fall on the same edge, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Timer counter value |
| mode_i | input | 3 | Timer operating mode code |
| cap_sel_i | input | 1 | Capture (1) / compare (0) select, used in free-running mode |
| edge_sel_i | input | 2 | Active capture edge select |
| cap_i | input | 1 | Asynchronous capture input |
| enable_i | input | 1 | Timer enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| value_o | output | 16 | Active register value |
| match_o | output | 1 | One-clock compare-match pulse |

## Verification
Writes and reload transfers show on `value_o` one edge after the stimulus, and `match_o` likewise reflects the conditions at the preceding edge. A capture appears three edges after `cap_i` changes, because of the two synchronizer stages and the edge register. The bench drives inputs on the falling clock edge and checks outputs on the next falling edge. A reference model is stepped once per cycle with the inputs that were stable across the rising edge. Directed capture checks step exactly three cycles, and they let the input settle before the next case so that no stale edge leaks forward.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [2:0] {
    MODE_FREE     = 3'd0,
    MODE_EVT      = 3'd1,
    MODE_ONESHOT  = 3'd2,
    MODE_INTERVAL = 3'd3,
    MODE_PWM      = 3'd4,
    MODE_TRIG     = 3'd5,
    MODE_PWMEAS   = 3'd6,
    MODE_SPARE    = 3'd7
  } tmr_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic capture;   // latch counter on edge
    logic compare;   // drive match
    logic reload;    // reload-buffered write mode
    logic wr_block;  // writes dropped
  } role_t;
endpackage

// File: rtl/tcc_role_dec.sv
module tcc_role_dec
  import tcc_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       cap_sel_i,
  output role_t      role_o
);
  tmr_mode_e mode;
  assign mode = tmr_mode_e'(mode_i);

  always_comb begin
    role_o = '{capture: 1'b0, compare: 1'b1, reload: 1'b0, wr_block: 1'b0};
    case (mode)
      MODE_FREE: begin
        role_o.capture = cap_sel_i;
        role_o.compare = ~cap_sel_i;
      end
      MODE_PWMEAS: begin
        role_o.capture  = 1'b1;
        role_o.compare  = 1'b0;
        role_o.wr_block = 1'b1;
      end
      MODE_PWM, MODE_TRIG: role_o.reload = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tcc_cap_edge.sv
module tcc_cap_edge
  import tcc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic [1:0] edge_sel_i,
  output logic       strobe_o
);
  localparam int unsigned LAST = SYNC_STAGES;

  // stages 0..SYNC_STAGES-1 synchronize, stage LAST holds previous sample
  logic [LAST:0] sh_q;

  for (genvar g = 0; g <= LAST; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= cap_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= sh_q[g-1];
      end
    end
  end

  logic rise, fall;
  assign rise = sh_q[LAST-1] & ~sh_q[LAST];
  assign fall = ~sh_q[LAST-1] & sh_q[LAST];

  always_comb begin
    case (edge_sel_e'(edge_sel_i))
      EDGE_RISE: strobe_o = rise;
      EDGE_FALL: strobe_o = fall;
      EDGE_BOTH: strobe_o = rise | fall;
      default:   strobe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcc_reg_core.sv
module tcc_reg_core
  import tcc_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  role_t            role_i,
  input  logic             enable_i,
  input  logic [WIDTH-1:0] count_i,
  input  logic             cap_stb_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] value_o,
  output logic             match_o
);
  logic [WIDTH-1:0] act_q, act_d, buf_q, buf_d;
  logic             match_q, match_d;
  logic             hit, boundary;

  assign hit      = (count_i == act_q);
  assign boundary = enable_i & hit;

  always_comb begin
    act_d = act_q;
    buf_d = buf_q;
    if (role_i.reload && boundary) act_d = buf_q;
    if (wr_en_i && !role_i.wr_block) begin
      if (role_i.reload && enable_i) begin
        buf_d = wr_data_i;
      end else begin
        act_d = wr_data_i;
        buf_d = wr_data_i;
      end
    end
    // capture overrides write
    if (role_i.capture && enable_i && cap_stb_i) begin
      act_d = count_i;
      buf_d = count_i;
    end
    match_d = role_i.compare & boundary;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= '0;
      buf_q   <= '0;
      match_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      buf_q   <= buf_d;
      match_q <= match_d;
    end
  end

  assign value_o = act_q;
  assign match_o = match_q;

  a_r6_no_capture_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !wr_en_i) |=> $stable(act_q));
endmodule

// File: rtl/tmr_capcmp_reg.sv
module tmr_capcmp_reg
  import tcc_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] count_i,
  input  logic [2:0]       mode_i,
  input  logic             cap_sel_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             cap_i,
  input  logic             enable_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] value_o,
  output logic             match_o
);
  role_t role;
  logic  cap_stb;

  tcc_role_dec u_role (
    .mode_i    (mode_i),
    .cap_sel_i (cap_sel_i),
    .role_o    (role)
  );

  tcc_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_i),
    .edge_sel_i (edge_sel_i),
    .strobe_o   (cap_stb)
  );

  tcc_reg_core #(.WIDTH(WIDTH)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .role_i    (role),
    .enable_i  (enable_i),
    .count_i   (count_i),
    .cap_stb_i (cap_stb),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .value_o   (value_o),
    .match_o   (match_o)
  );

  logic is_meas, is_reload;
  assign is_meas   = (mode_i == MODE_PWMEAS);
  assign is_reload = (mode_i == MODE_PWM) || (mode_i == MODE_TRIG);

  a_r3_no_match_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_meas |=> !match_o);

  a_r10_meas_only_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_meas && !cap_stb) |=> $stable(value_o));

  a_r7_reload_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_reload && enable_i && count_i != value_o) |=> $stable(value_o));

  a_r11_match_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ($past(enable_i) && $past(count_i == value_o)));
endmodule

// File: tb/tmr_capcmp_reg_bench.sv
module tmr_capcmp_reg_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] count_i = '0;
  logic [2:0]  mode_i = 3'd3;
  logic        cap_sel_i = 1'b0;
  logic [1:0]  edge_sel_i = 2'b01;
  logic        cap_i = 1'b0;
  logic        enable_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] value_o;
  logic        match_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_capcmp_reg u_tmr_capcmp_reg (
    .clk_i(clk), .rst_ni(rst_ni), .count_i(count_i), .mode_i(mode_i),
    .cap_sel_i(cap_sel_i), .edge_sel_i(edge_sel_i), .cap_i(cap_i),
    .enable_i(enable_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .value_o(value_o), .match_o(match_o)
  );

  // reference model state
  logic        m_s0 = 0, m_s1 = 0, m_s2 = 0;
  logic [15:0] m_act = '0, m_buf = '0;
  logic        m_match = 0;

  function automatic bit f_capture(input logic [2:0] m, input logic sel);
    return (m == 3'd6) || (m == 3'd0 && sel);
  endfunction
  function automatic bit f_compare(input logic [2:0] m, input logic sel);
    return (m != 3'd6) && !(m == 3'd0 && sel);
  endfunction
  function automatic bit f_edge(input logic [1:0] es, input logic now, input logic prev);
    return (es[0] && now && !prev) || (es[1] && !now && prev);
  endfunction

  task automatic model_next();
    logic [15:0] na = m_act, nb = m_buf;
    bit reload = (mode_i == 3'd4) || (mode_i == 3'd5);
    bit bnd    = enable_i && (count_i == m_act);
    bit stb    = f_edge(edge_sel_i, m_s1, m_s2);
    if (reload && bnd) na = m_buf;
    if (wr_en_i && mode_i != 3'd6) begin
      if (reload && enable_i) nb = wr_data_i;
      else begin na = wr_data_i; nb = wr_data_i; end
    end
    if (f_capture(mode_i, cap_sel_i) && enable_i && stb) begin
      na = count_i; nb = count_i;
    end
    m_match = f_compare(mode_i, cap_sel_i) && bnd;
    m_act = na; m_buf = nb;
    m_s2 = m_s1; m_s1 = m_s0; m_s0 = cap_i;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    model_next();
    @(negedge clk);
    chk({tag, " value"}, value_o, m_act);
    chk({tag, " match"}, {15'd0, match_o}, {15'd0, m_match});
  endtask

  task automatic wr(input logic [15:0] d, input string tag);
    wr_en_i = 1'b1; wr_data_i = d;
    step(tag);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0011));
    repeat (2) @(negedge clk);
    chk("R1 reset value", value_o, 16'h0000);
    chk("R1 reset match", {15'd0, match_o}, 16'h0);
    rst_ni = 1'b1;
    step("R1 first");
    chk("R1 zero compare hit", {15'd0, match_o}, 16'h1);

    count_i = 16'h0100;
    wr(16'h1234, "R9 immediate");
    chk("R9 write", value_o, 16'h1234);
    count_i = 16'h1234; step("R11");
    chk("R11 match high", {15'd0, match_o}, 16'h1);
    count_i = 16'h1235; step("R11");
    chk("R11 match low", {15'd0, match_o}, 16'h0);

    mode_i = 3'd4;
    wr(16'h0050, "R7 buffered");
    chk("R7 hold", value_o, 16'h1234);
    count_i = 16'h1234; step("R8");
    chk("R8 transfer", value_o, 16'h0050);
    chk("R11 match at boundary", {15'd0, match_o}, 16'h1);
    count_i = 16'h0001; step("R8");

    mode_i = 3'd6;
    wr(16'hAAAA, "R10");
    chk("R10 ignored", value_o, 16'h0050);
    count_i = 16'h0050; step("R3");
    chk("R3 no match", {15'd0, match_o}, 16'h0);

    count_i = 16'h0777; cap_i = 1'b1;
    repeat (3) step("R5 rise");
    chk("R5 rising capture", value_o, 16'h0777);
    step("R5");
    count_i = 16'h0888; cap_i = 1'b0;
    repeat (4) step("R5 fall ignored");
    chk("R5 falling ignored", value_o, 16'h0777);
    edge_sel_i = 2'b10; cap_i = 1'b1;
    repeat (4) step("R5 rise ignored");
    chk("R5 rising ignored", value_o, 16'h0777);
    cap_i = 1'b0;
    repeat (3) step("R5 fall");
    chk("R5 falling capture", value_o, 16'h0888);
    step("R5");
    edge_sel_i = 2'b11; count_i = 16'h0999; cap_i = 1'b1;
    repeat (3) step("R5 both");
    chk("R5 both capture", value_o, 16'h0999);
    step("R5");

    enable_i = 1'b0; count_i = 16'h0AAA; cap_i = 1'b0;
    repeat (4) step("R6");
    chk("R6 disabled", value_o, 16'h0999);
    enable_i = 1'b1;

    mode_i = 3'd0; cap_sel_i = 1'b1; count_i = 16'h0BBB; cap_i = 1'b1;
    repeat (3) step("R2 cap");
    chk("R2 free-run capture", value_o, 16'h0BBB);
    step("R2");
    cap_sel_i = 1'b0; count_i = 16'h0CCC; cap_i = 1'b0;
    repeat (4) step("R2 cmp");
    chk("R2 compare no capture", value_o, 16'h0BBB);
    count_i = 16'h0BBB; step("R2");
    chk("R2 compare match", {15'd0, match_o}, 16'h1);

    mode_i = 3'd1; cap_sel_i = 1'b1; count_i = 16'h0DDD; cap_i = 1'b1;
    repeat (4) step("R4");
    chk("R4 no capture", value_o, 16'h0BBB);
    count_i = 16'h0BBB; step("R4");
    chk("R4 match", {15'd0, match_o}, 16'h1);

    mode_i = 3'd0; cap_sel_i = 1'b1; count_i = 16'h0EEE; cap_i = 1'b0;
    repeat (2) step("R12");
    wr(16'h1111, "R12");
    chk("R12 capture wins", value_o, 16'h0EEE);
    step("R12");

    mode_i = 3'd4; enable_i = 1'b0;
    wr(16'h2222, "R9 disabled");
    chk("R9 reload-mode disabled write", value_o, 16'h2222);

    for (int i = 0; i < 3000; i++) begin
      mode_i     = 3'($urandom_range(0, 7));
      enable_i   = ($urandom % 8) != 0;
      cap_sel_i  = 1'($urandom);
      edge_sel_i = 2'($urandom);
      cap_i      = 1'($urandom);
      wr_en_i    = ($urandom % 4) == 0;
      wr_data_i  = 16'($urandom_range(0, 7));
      count_i    = 16'($urandom_range(0, 7));
      step("R2/R4/R5/R7/R8/R9/R11 random");
    end
    wr_en_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule